// File: doc/BRIEF.md
# Debounced Double-Edge Input Detector

This block takes one raw digital input and turns it into a clean, debounced logic level. A built-in clock divider produces a periodic check strobe. On each strobe the raw input is compared with the current debounced state. The state moves to the new level only after the input has disagreed with it on a set number of consecutive strobes. Rising and falling transitions each have their own count.

When the state changes, the block can raise a one-clock event. In single-edge mode the event fires only when the new state is the active level. In double-edge mode it fires on every accepted change. A polarity control makes the low level the active one. Three outputs are available: the debounced state, the polarity-adjusted level and the event pulse.

The raw input is expected to be synchronous to `clk`; any synchronisation from another clock domain is done upstream.

Top module: `dbn_edge_detect`

## Requirements
- R1: A check strobe occurs once every `CHECK_DIV` clocks. The first strobe lands on the `CHECK_DIV`-th rising edge after the last edge with `rst` high. The debounced state changes only on a strobe edge.
- R2: A low-to-high change is accepted on the `RISE_CHECKS`-th consecutive strobe at which the raw input is 1 while the state is 0.
- R3: A high-to-low change is accepted on the `FALL_CHECKS`-th consecutive strobe at which the raw input is 0 while the state is 1.
- R4: A strobe that finds the raw input equal to the state reloads the count for the transition away from that state. Any run of disagreement therefore starts over from its full length.
- R5: With `SEED_FROM_INPUT` = 0, a synchronous reset (`rst` = 1) clears the state to 0, holds `event_o` at 0 and loads the low-to-high count. This also applies when reset is asserted during operation.
- R6: With `SEED_FROM_INPUT` = 1, reset loads the state from `raw_in`. The count is loaded for the transition away from that level.
- R7: `event_o` is a single-clock pulse. It is high in the clock cycle that immediately follows the edge on which the state updates.
- R8: With `both_edges` = 0, an event fires only when the new state is active. The active state is 1 when `active_low` = 0 and 0 when `active_low` = 1.
- R9: With `both_edges` = 1, every accepted change produces an event.
- R10: `level_o` equals the debounced state XOR `active_low`.
- R11: A raw pulse that starts and ends between two strobes has no effect on the state or the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 1 | Raw input to be filtered |
| active_low | input | 1 | 1: the low level is the active level |
| both_edges | input | 1 | 1: report every accepted change |
| state_o | output | 1 | Debounced state, without polarity adjustment |
| level_o | output | 1 | Debounced state adjusted for polarity |
| event_o | output | 1 | One-clock event pulse on a qualifying change |

## Verification
The hardest situation to reach from the ports is a disagreement run that is broken by a single agreeing strobe. The expected counts are only visible indirectly, through the strobe on which the state finally flips.

The stimulus holds the raw input for whole strobe periods, counted from reset release, so every step contains exactly one strobe on its last edge. A matching step is placed in the middle of a falling run, and a one-clock glitch is placed away from the strobe edge. The flip point then shows whether the count was reloaded or left untouched.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
   function automatic int unsigned dbn_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned dbn_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dbn_tick_gen.sv
module dbn_tick_gen #(
   parameter int unsigned CHECK_DIV = 200000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   import dbn_pkg::*;
   localparam int unsigned CW = dbn_width(CHECK_DIV);

   initial begin
      if (CHECK_DIV < 1) $error("CHECK_DIV must be at least 1");
   end

   generate
      if (CHECK_DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else if (cnt_q == CW'(CHECK_DIV - 1)) cnt_q <= '0;
            else cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == CW'(CHECK_DIV - 1));

         // R1: strobes are never back to back
         p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/dbn_filter.sv
module dbn_filter #(
   parameter int unsigned RISE_CHECKS     = 2,
   parameter int unsigned FALL_CHECKS     = 2,
   parameter bit          SEED_FROM_INPUT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic raw_i,
   output logic state_o,
   output logic accept_o
);
   import dbn_pkg::*;
   localparam int unsigned MAXC = dbn_max(RISE_CHECKS, FALL_CHECKS);
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] RISE_LD = CW'(RISE_CHECKS);
   localparam logic [CW-1:0] FALL_LD = CW'(FALL_CHECKS);

   initial begin
      if (RISE_CHECKS < 1) $error("RISE_CHECKS must be at least 1");
      if (FALL_CHECKS < 1) $error("FALL_CHECKS must be at least 1");
   end

   logic          state_q, acc_q;
   logic [CW-1:0] cnt_q;
   logic          seed_state;

   generate
      if (SEED_FROM_INPUT) begin : g_seed_raw
         assign seed_state = raw_i;
      end else begin : g_seed_zero
         assign seed_state = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= seed_state;
         cnt_q   <= seed_state ? FALL_LD : RISE_LD;
         acc_q   <= 1'b0;
      end else begin
         acc_q <= 1'b0;
         if (tick_i) begin
            if (raw_i == state_q) begin
               cnt_q <= state_q ? FALL_LD : RISE_LD;
            end else if (cnt_q == CW'(1)) begin
               state_q <= raw_i;
               cnt_q   <= raw_i ? FALL_LD : RISE_LD;
               acc_q   <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign state_o  = state_q;
   assign accept_o = acc_q;

   // R1: state moves only on a strobe
   p_state_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(state_q));
   // R4: agreement reloads the count for the opposite transition
   p_reload_match_r4: assert property (@(posedge clk) disable iff (rst)
      (tick_i && raw_i == state_q) |=> cnt_q == ($past(state_q) ? FALL_LD : RISE_LD));
   // R2, R3: count stays within its loaded range
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q >= CW'(1) && cnt_q <= CW'(MAXC));
   // R7: acceptance coincides with a state change
   p_accept_change_r7: assert property (@(posedge clk) disable iff (rst)
      acc_q |-> state_q != $past(state_q));
endmodule

// File: rtl/dbn_event.sv
module dbn_event (
   input  logic clk,
   input  logic rst,
   input  logic state_i,
   input  logic accept_i,
   input  logic active_low,
   input  logic both_edges,
   output logic level_o,
   output logic event_o
);
   assign level_o = state_i ^ active_low;
   assign event_o = accept_i & (both_edges | level_o);

   // R8: single-edge events only on the active level
   p_evt_active_r8: assert property (@(posedge clk) disable iff (rst)
      (event_o && !both_edges) |-> level_o);
   // R9: every acceptance is reported in double-edge mode
   p_evt_both_r9: assert property (@(posedge clk) disable iff (rst)
      (accept_i && both_edges) |-> event_o);
endmodule

// File: rtl/dbn_edge_detect.sv
module dbn_edge_detect #(
   parameter int unsigned CHECK_DIV       = 200000,
   parameter int unsigned RISE_CHECKS     = 2,
   parameter int unsigned FALL_CHECKS     = 2,
   parameter bit          SEED_FROM_INPUT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_in,
   input  logic active_low,
   input  logic both_edges,
   output logic state_o,
   output logic level_o,
   output logic event_o
);
   logic tick, accept;

   dbn_tick_gen #(.CHECK_DIV(CHECK_DIV)) u_tick (
      .clk(clk), .rst(rst), .tick_o(tick)
   );

   dbn_filter #(
      .RISE_CHECKS(RISE_CHECKS), .FALL_CHECKS(FALL_CHECKS),
      .SEED_FROM_INPUT(SEED_FROM_INPUT)
   ) u_filter (
      .clk(clk), .rst(rst), .tick_i(tick), .raw_i(raw_in),
      .state_o(state_o), .accept_o(accept)
   );

   dbn_event u_event (
      .clk(clk), .rst(rst), .state_i(state_o), .accept_i(accept),
      .active_low(active_low), .both_edges(both_edges),
      .level_o(level_o), .event_o(event_o)
   );

   // R7: event never lasts past one clock with spaced strobes
   p_evt_single_r7: assert property (@(posedge clk) disable iff (rst)
      (event_o && CHECK_DIV > 1) |=> !event_o);
endmodule

// File: tb/dbn_edge_detect_tb_top.sv
`timescale 1ns/1ps
module dbn_edge_detect_tb_top;
   localparam int DIV  = 4;
   localparam int RISE = 2;
   localparam int FALL = 3;
   localparam int NV   = 17;

   // fields: {raw, both_edges, active_low, expected state, expected event}
   localparam logic [4:0] VEC [NV] = '{
      5'b1_0_0_0_0, // R2 first rising check
      5'b1_0_0_1_1, // R2 accept, R8 active rise
      5'b0_0_0_1_0, // R3 falling run starts
      5'b1_0_0_1_0, // R4 agreement reloads
      5'b0_0_0_1_0,
      5'b0_0_0_1_0,
      5'b0_0_0_0_0, // R3 accept, R8 inactive fall
      5'b1_1_0_0_0,
      5'b1_1_0_1_1, // R9 rise
      5'b0_1_0_1_0,
      5'b0_1_0_1_0,
      5'b0_1_0_0_1, // R9 fall
      5'b1_0_1_0_0,
      5'b1_0_1_1_0, // R8 rise inactive when active low
      5'b0_0_1_1_0,
      5'b0_0_1_1_0,
      5'b0_0_1_0_1  // R8 fall active when active low
   };

   logic clk = 1'b0, rst = 1'b1, raw = 1'b0, al = 1'b0, dbl = 1'b0, raw_b = 1'b1;
   logic st, lv, ev, st_b, lv_b, ev_b;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dbn_edge_detect #(.CHECK_DIV(DIV), .RISE_CHECKS(RISE), .FALL_CHECKS(FALL),
                     .SEED_FROM_INPUT(1'b0)) dut_i (
      .clk(clk), .rst(rst), .raw_in(raw), .active_low(al), .both_edges(dbl),
      .state_o(st), .level_o(lv), .event_o(ev));

   dbn_edge_detect #(.CHECK_DIV(DIV), .RISE_CHECKS(RISE), .FALL_CHECKS(FALL),
                     .SEED_FROM_INPUT(1'b1)) dut_seed_i (
      .clk(clk), .rst(rst), .raw_in(raw_b), .active_low(1'b0), .both_edges(1'b0),
      .state_o(st_b), .level_o(lv_b), .event_o(ev_b));

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   // one strobe period; strobe is on the last rising edge
   task automatic step(input logic r);
      raw = r;
      repeat (DIV) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      al = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 reset state", st, 1'b0);
      chk("R5 reset event", ev, 1'b0);
      chk("R10 reset level", lv, 1'b1);
      chk("R6 seeded state", st_b, 1'b1);
      al = 1'b0;
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         dbl = VEC[i][3];
         al  = VEC[i][2];
         step(VEC[i][4]);
         chk($sformatf("R2 R3 R4 state vec %0d", i), st, VEC[i][1]);
         chk($sformatf("R7 R8 R9 event vec %0d", i), ev, VEC[i][0]);
         chk($sformatf("R10 level vec %0d", i), lv, VEC[i][1] ^ VEC[i][2]);
         if (VEC[i][0]) begin
            @(posedge clk); @(negedge clk);
            chk("R7 pulse ends", ev, 1'b0);
            // re-align: consume rest of period without a strobe change
            repeat (DIV - 1) @(posedge clk);
            @(negedge clk);
            i = i; // next step resumes on period boundary
         end
      end

      // R11: glitch away from strobe edge, state 0, active low, single edge
      raw = 1'b1;
      @(posedge clk); @(negedge clk);
      raw = 1'b0;
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      chk("R11 glitch ignored", st, 1'b0);
      step(1'b1);
      chk("R11 count intact", st, 1'b0);
      step(1'b1);
      chk("R2 R11 rise after full count", st, 1'b1);
      chk("R8 no event on inactive rise", ev, 1'b0);

      // R6: seeded instance falls after FALL checks
      raw_b = 1'b0;
      for (int k = 1; k < FALL; k++) begin
         step(1'b1);
         chk("R3 R6 seeded still high", st_b, 1'b1);
      end
      step(1'b1);
      chk("R3 R6 seeded falls", st_b, 1'b0);

      // R5: reset during operation
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R5 mid reset state", st, 1'b0);
      chk("R5 mid reset event", ev, 1'b0);
      rst = 1'b0;
      step(1'b1);
      chk("R1 R5 first strobe after reset", st, 1'b0);
      step(1'b1);
      chk("R1 R5 rise after reload", st, 1'b1);

      done = 1'b1;
      finish_run();
   end
endmodule